// File: doc/BRIEF.md
# PIPE Data Bus Width Converter (2:1 Gearbox)

This block sits between a PHY-side data path that moves two symbols per cycle on the full-rate interface clock and a controller-side data path that moves four symbols per cycle on a clock running at half that rate. Both clocks are treated as one synchronous system: every rising edge of the half-rate clock coincides with a rising edge of the full-rate clock. On receive, two consecutive narrow beats (data, K flags, receiver valid, PHY status pulse and receiver status code) are joined into one wide beat. Status is not merged: each narrow cycle keeps its own bit or field on the wide side. On transmit, one wide word with its K flags is split into two narrow beats.

Symbol order in time is kept strictly across the width change: on any bus the least significant symbol is the earliest one. A static phase input tells the block which full-rate edge after reset starts a pair. The integrator sets it so that pair starts fall on the full-rate edges that coincide with half-rate edges. The latency in both directions is fixed by the stage-count parameters.

Top module: `pipe_gearbox`

## Requirements
- R1: While `rst` is high, every wide receive output and every narrow transmit output is zero at the next edge of its clock, whatever the inputs carry.
- R2: On receive, the earlier narrow beat of a pair lands in wide data bits [15:0] and K bits [1:0], and the later beat lands in bits [31:16] and K bits [3:2]. Within each narrow beat, bits [7:0] and K bit 0 are the earlier symbol.
- R3: Wide `phy_status_w` bit 0 carries the PHY status of the earlier narrow beat, and bit 1 carries that of the later beat.
- R4: Wide `rx_status_w` bits [2:0] carry the 3-bit receiver status of the earlier narrow beat, and bits [5:3] carry that of the later beat.
- R5: Wide `rx_valid_w` is 1 only when both narrow beats of the pair had `rx_valid_n` at 1.
- R6: A pair whose earlier beat is sampled at the full-rate edge that coincides with half-rate edge k shows on the wide outputs after half-rate edge k+RX_STAGES (k+1 with defaults) and holds for one half-rate cycle.
- R7: On transmit, bits [15:0] and K bits [1:0] of a wide word go out on the first narrow cycle, and bits [31:16] with K bits [3:2] go out on the next narrow cycle.
- R8: A wide transmit word sampled at half-rate edge k drives its lower half onto the narrow outputs after the coincident full-rate edge of half-rate edge k+TX_STAGES (k+1 with defaults), and its upper half after the full-rate edge that follows.
- R9: With `phase_sel` at 0, the first full-rate edge after reset release is a pair start. With `phase_sel` at 1, that edge is a pair end. After it, starts and ends alternate on every full-rate edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Full-rate PHY interface clock |
| clk_half | input | 1 | Half-rate clock, rising edges aligned with clk_fast |
| rst | input | 1 | Synchronous active-high reset for both clock domains |
| phase_sel | input | 1 | Static pair phase select (R9) |
| rx_data_n | input | 16 | Narrow receive data, two symbols |
| rx_k_n | input | 2 | Narrow receive K flags |
| rx_valid_n | input | 1 | Narrow receiver valid |
| phy_status_n | input | 1 | Narrow PHY status pulse |
| rx_status_n | input | 3 | Narrow receiver status code |
| rx_data_w | output | 32 | Wide receive data, four symbols |
| rx_k_w | output | 4 | Wide receive K flags |
| rx_valid_w | output | 1 | Wide receiver valid, both halves valid |
| phy_status_w | output | 2 | PHY status per narrow cycle |
| rx_status_w | output | 6 | Receiver status per narrow cycle |
| tx_data_w | input | 32 | Wide transmit data, four symbols |
| tx_k_w | input | 4 | Wide transmit K flags |
| tx_data_n | output | 16 | Narrow transmit data |
| tx_k_n | output | 2 | Narrow transmit K flags |

## Verification
Receive gathering and transmit splitting run in the same full-rate cycles and share the pair phase. The bench drives both directions at once from concurrent driver tasks, so every pair start and pair end sees a receive capture and a transmit emission together. The receive stream also places a receiver-valid drop, a PHY status pulse or a distinct status code in a beat that carries K symbols, so the per-cycle status fields and the data halves must come out of the same pair. Each direction has its own scoreboard queue keyed by the half-rate cycle count, so a swapped pairing, a shifted phase or a wrong latency shows up as a mismatch on the cycle where it occurs.

// File: rtl/pipe_gear_pkg.sv
package pipe_gear_pkg;

   // Number of narrow beats packed into one wide beat.
   localparam int unsigned GEAR_RATIO = 2;

   // Position of a full-rate cycle inside a pair.
   typedef enum logic {
      SLOT_FIRST  = 1'b0,
      SLOT_SECOND = 1'b1
   } slot_e;

endpackage

// File: rtl/pipe_gear_phase.sv
module pipe_gear_phase
   import pipe_gear_pkg::*;
(
   input  logic  clk_fast,
   input  logic  rst,
   input  logic  phase_sel,
   output slot_e slot
);

   logic toggle_q;

   always_ff @(posedge clk_fast) begin
      if (rst) toggle_q <= 1'b0;
      else     toggle_q <= ~toggle_q;
   end

   // The toggle is zero on the first edge after release, so phase_sel names that edge.
   assign slot = slot_e'(toggle_q ^ phase_sel);

   assert_slot_alternates_R9: assert property (
      @(posedge clk_fast) disable iff (rst)
      !$past(rst) |-> (slot != $past(slot))
   );

endmodule

// File: rtl/pipe_gear_rx.sv
module pipe_gear_rx
   import pipe_gear_pkg::*;
#(
   parameter int unsigned SYM_W  = 8,
   parameter int unsigned N_SYMS = 2,
   parameter int unsigned STAT_W = 3,
   parameter int unsigned STAGES = 1
) (
   input  logic                                  clk_fast,
   input  logic                                  clk_half,
   input  logic                                  rst,
   input  slot_e                                 slot,
   input  logic [SYM_W*N_SYMS-1:0]               rx_data_n,
   input  logic [N_SYMS-1:0]                     rx_k_n,
   input  logic                                  rx_valid_n,
   input  logic                                  phy_status_n,
   input  logic [STAT_W-1:0]                     rx_status_n,
   output logic [GEAR_RATIO*SYM_W*N_SYMS-1:0]    rx_data_w,
   output logic [GEAR_RATIO*N_SYMS-1:0]          rx_k_w,
   output logic                                  rx_valid_w,
   output logic [GEAR_RATIO-1:0]                 phy_status_w,
   output logic [GEAR_RATIO*STAT_W-1:0]          rx_status_w
);

   localparam int unsigned NDW = SYM_W * N_SYMS;
   localparam int unsigned WDW = GEAR_RATIO * NDW;
   localparam int unsigned WKW = GEAR_RATIO * N_SYMS;
   localparam int unsigned WSW = GEAR_RATIO * STAT_W;
   localparam int unsigned BW  = WDW + WKW + 1 + GEAR_RATIO + WSW;

   // ---------------- earlier beat, held across one full-rate cycle
   logic [NDW-1:0]    first_data_q;
   logic [N_SYMS-1:0] first_k_q;
   logic              first_valid_q;
   logic              first_phy_q;
   logic [STAT_W-1:0] first_stat_q;

   always_ff @(posedge clk_fast) begin
      if (rst) begin
         first_data_q  <= '0;
         first_k_q     <= '0;
         first_valid_q <= 1'b0;
         first_phy_q   <= 1'b0;
         first_stat_q  <= '0;
      end else if (slot == SLOT_FIRST) begin
         first_data_q  <= rx_data_n;
         first_k_q     <= rx_k_n;
         first_valid_q <= rx_valid_n;
         first_phy_q   <= phy_status_n;
         first_stat_q  <= rx_status_n;
      end
   end

   // ---------------- per-half sources: index 0 is earlier in time
   logic [NDW-1:0]    half_data  [GEAR_RATIO];
   logic [N_SYMS-1:0] half_k     [GEAR_RATIO];
   logic [STAT_W-1:0] half_stat  [GEAR_RATIO];
   logic [GEAR_RATIO-1:0] half_valid;
   logic [GEAR_RATIO-1:0] half_phy;

   assign half_data[0] = first_data_q;
   assign half_data[1] = rx_data_n;
   assign half_k[0]    = first_k_q;
   assign half_k[1]    = rx_k_n;
   assign half_stat[0] = first_stat_q;
   assign half_stat[1] = rx_status_n;
   assign half_valid   = {rx_valid_n, first_valid_q};
   assign half_phy     = {phy_status_n, first_phy_q};

   logic [WDW-1:0] join_data;
   logic [WKW-1:0] join_k;
   logic [WSW-1:0] join_stat;

   for (genvar h = 0; h < GEAR_RATIO; h++) begin : g_join
      assign join_data[h*NDW    +: NDW]    = half_data[h];
      assign join_k   [h*N_SYMS +: N_SYMS] = half_k[h];
      assign join_stat[h*STAT_W +: STAT_W] = half_stat[h];
   end

   // ---------------- completed pair, stable for two full-rate cycles
   logic [WDW-1:0]        pair_data_q;
   logic [WKW-1:0]        pair_k_q;
   logic                  pair_valid_q;
   logic [GEAR_RATIO-1:0] pair_phy_q;
   logic [WSW-1:0]        pair_stat_q;

   always_ff @(posedge clk_fast) begin
      if (rst) begin
         pair_data_q  <= '0;
         pair_k_q     <= '0;
         pair_valid_q <= 1'b0;
         pair_phy_q   <= '0;
         pair_stat_q  <= '0;
      end else if (slot == SLOT_SECOND) begin
         pair_data_q  <= join_data;
         pair_k_q     <= join_k;
         pair_valid_q <= &half_valid;
         pair_phy_q   <= half_phy;
         pair_stat_q  <= join_stat;
      end
   end

   assert_rx_early_low_R2: assert property (
      @(posedge clk_fast) disable iff (rst)
      (slot == SLOT_SECOND && !$past(rst)) |=>
         (pair_data_q[NDW-1:0] == $past(rx_data_n, 2)) &&
         (pair_k_q[N_SYMS-1:0] == $past(rx_k_n, 2))
   );

   assert_rx_late_high_R2: assert property (
      @(posedge clk_fast) disable iff (rst)
      (slot == SLOT_SECOND && !$past(rst)) |=>
         (pair_data_q[WDW-1:NDW] == $past(rx_data_n, 1)) &&
         (pair_k_q[WKW-1:N_SYMS] == $past(rx_k_n, 1))
   );

   assert_rx_phy_split_R3: assert property (
      @(posedge clk_fast) disable iff (rst)
      (slot == SLOT_SECOND && !$past(rst)) |=>
         (pair_phy_q == {$past(phy_status_n, 1), $past(phy_status_n, 2)})
   );

   assert_rx_status_split_R4: assert property (
      @(posedge clk_fast) disable iff (rst)
      (slot == SLOT_SECOND && !$past(rst)) |=>
         (pair_stat_q == {$past(rx_status_n, 1), $past(rx_status_n, 2)})
   );

   assert_rx_valid_both_R5: assert property (
      @(posedge clk_fast) disable iff (rst)
      (slot == SLOT_SECOND && !$past(rst)) |=>
         (pair_valid_q == ($past(rx_valid_n, 1) && $past(rx_valid_n, 2)))
   );

   // ---------------- half-rate output stages
   logic [BW-1:0] pair_bundle;
   assign pair_bundle = {pair_data_q, pair_k_q, pair_valid_q, pair_phy_q, pair_stat_q};

   logic [BW-1:0] out_bundle;

   if (STAGES == 1) begin : g_single
      logic [BW-1:0] stage_q;
      always_ff @(posedge clk_half) begin
         if (rst) stage_q <= '0;
         else     stage_q <= pair_bundle;
      end
      assign out_bundle = stage_q;
   end else begin : g_chain
      logic [BW-1:0] stage_q [STAGES];
      always_ff @(posedge clk_half) begin
         if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
         end else begin
            stage_q[0] <= pair_bundle;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
         end
      end
      assign out_bundle = stage_q[STAGES-1];
   end

   assign {rx_data_w, rx_k_w, rx_valid_w, phy_status_w, rx_status_w} = out_bundle;

endmodule

// File: rtl/pipe_gear_tx.sv
module pipe_gear_tx
   import pipe_gear_pkg::*;
#(
   parameter int unsigned SYM_W  = 8,
   parameter int unsigned N_SYMS = 2,
   parameter int unsigned STAGES = 1
) (
   input  logic                               clk_fast,
   input  logic                               clk_half,
   input  logic                               rst,
   input  slot_e                              slot,
   input  logic [GEAR_RATIO*SYM_W*N_SYMS-1:0] tx_data_w,
   input  logic [GEAR_RATIO*N_SYMS-1:0]       tx_k_w,
   output logic [SYM_W*N_SYMS-1:0]            tx_data_n,
   output logic [N_SYMS-1:0]                  tx_k_n
);

   localparam int unsigned NDW = SYM_W * N_SYMS;
   localparam int unsigned WDW = GEAR_RATIO * NDW;
   localparam int unsigned WKW = GEAR_RATIO * N_SYMS;
   localparam int unsigned HW  = WDW + WKW;

   // ---------------- half-rate hold stages
   logic [HW-1:0]  in_bundle;
   logic [HW-1:0]  hold_bundle;
   logic [WDW-1:0] hold_data;
   logic [WKW-1:0] hold_k;

   assign in_bundle = {tx_data_w, tx_k_w};

   if (STAGES == 1) begin : g_single
      logic [HW-1:0] stage_q;
      always_ff @(posedge clk_half) begin
         if (rst) stage_q <= '0;
         else     stage_q <= in_bundle;
      end
      assign hold_bundle = stage_q;
   end else begin : g_chain
      logic [HW-1:0] stage_q [STAGES];
      always_ff @(posedge clk_half) begin
         if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
         end else begin
            stage_q[0] <= in_bundle;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
         end
      end
      assign hold_bundle = stage_q[STAGES-1];
   end

   assign {hold_data, hold_k} = hold_bundle;

   // ---------------- split into halves: index 0 leaves first
   logic [NDW-1:0]    split_data [GEAR_RATIO];
   logic [N_SYMS-1:0] split_k    [GEAR_RATIO];

   for (genvar h = 0; h < GEAR_RATIO; h++) begin : g_split
      assign split_data[h] = hold_data[h*NDW    +: NDW];
      assign split_k[h]    = hold_k   [h*N_SYMS +: N_SYMS];
   end

   // ---------------- full-rate emission with a stash for the later half
   logic [NDW-1:0]    out_data_q, stash_data_q;
   logic [N_SYMS-1:0] out_k_q,    stash_k_q;

   always_ff @(posedge clk_fast) begin
      if (rst) begin
         out_data_q   <= '0;
         out_k_q      <= '0;
         stash_data_q <= '0;
         stash_k_q    <= '0;
      end else if (slot == SLOT_FIRST) begin
         out_data_q   <= split_data[0];
         out_k_q      <= split_k[0];
         stash_data_q <= split_data[1];
         stash_k_q    <= split_k[1];
      end else begin
         out_data_q   <= stash_data_q;
         out_k_q      <= stash_k_q;
      end
   end

   assign tx_data_n = out_data_q;
   assign tx_k_n    = out_k_q;

   assert_tx_low_first_R7: assert property (
      @(posedge clk_fast) disable iff (rst)
      (slot == SLOT_FIRST && !$past(rst)) |=>
         (tx_data_n == $past(hold_data[NDW-1:0], 1)) &&
         (tx_k_n    == $past(hold_k[N_SYMS-1:0], 1))
   );

   assert_tx_high_next_R7: assert property (
      @(posedge clk_fast) disable iff (rst)
      (slot == SLOT_SECOND && !$past(rst)) |=>
         (tx_data_n == $past(hold_data[WDW-1:NDW], 2)) &&
         (tx_k_n    == $past(hold_k[WKW-1:N_SYMS], 2))
   );

endmodule

// File: rtl/pipe_gearbox.sv
module pipe_gearbox
   import pipe_gear_pkg::*;
#(
   parameter int unsigned SYM_W       = 8,
   parameter int unsigned NARROW_SYMS = 2,
   parameter int unsigned STATUS_W    = 3,
   parameter int unsigned RX_STAGES   = 1,
   parameter int unsigned TX_STAGES   = 1
) (
   input  logic                                    clk_fast,
   input  logic                                    clk_half,
   input  logic                                    rst,
   input  logic                                    phase_sel,
   input  logic [SYM_W*NARROW_SYMS-1:0]            rx_data_n,
   input  logic [NARROW_SYMS-1:0]                  rx_k_n,
   input  logic                                    rx_valid_n,
   input  logic                                    phy_status_n,
   input  logic [STATUS_W-1:0]                     rx_status_n,
   output logic [GEAR_RATIO*SYM_W*NARROW_SYMS-1:0] rx_data_w,
   output logic [GEAR_RATIO*NARROW_SYMS-1:0]       rx_k_w,
   output logic                                    rx_valid_w,
   output logic [GEAR_RATIO-1:0]                   phy_status_w,
   output logic [GEAR_RATIO*STATUS_W-1:0]          rx_status_w,
   input  logic [GEAR_RATIO*SYM_W*NARROW_SYMS-1:0] tx_data_w,
   input  logic [GEAR_RATIO*NARROW_SYMS-1:0]       tx_k_w,
   output logic [SYM_W*NARROW_SYMS-1:0]            tx_data_n,
   output logic [NARROW_SYMS-1:0]                  tx_k_n
);

   localparam int unsigned MAX_STAGES = 4;

   // ---------------- elaboration-time parameter checks
   if (GEAR_RATIO != 2) begin : g_bad_ratio
      $error("pipe_gearbox supports a 2:1 ratio only");
   end
   if (SYM_W == 0 || NARROW_SYMS == 0 || STATUS_W == 0) begin : g_bad_width
      $error("pipe_gearbox widths must be non-zero");
   end
   if (RX_STAGES < 1 || RX_STAGES > MAX_STAGES) begin : g_bad_rx
      $error("pipe_gearbox RX_STAGES out of range");
   end
   if (TX_STAGES < 1 || TX_STAGES > MAX_STAGES) begin : g_bad_tx
      $error("pipe_gearbox TX_STAGES out of range");
   end

   slot_e slot;

   pipe_gear_phase u_phase (
      .clk_fast  (clk_fast),
      .rst       (rst),
      .phase_sel (phase_sel),
      .slot      (slot)
   );

   pipe_gear_rx #(
      .SYM_W  (SYM_W),
      .N_SYMS (NARROW_SYMS),
      .STAT_W (STATUS_W),
      .STAGES (RX_STAGES)
   ) u_rx (
      .clk_fast     (clk_fast),
      .clk_half     (clk_half),
      .rst          (rst),
      .slot         (slot),
      .rx_data_n    (rx_data_n),
      .rx_k_n       (rx_k_n),
      .rx_valid_n   (rx_valid_n),
      .phy_status_n (phy_status_n),
      .rx_status_n  (rx_status_n),
      .rx_data_w    (rx_data_w),
      .rx_k_w       (rx_k_w),
      .rx_valid_w   (rx_valid_w),
      .phy_status_w (phy_status_w),
      .rx_status_w  (rx_status_w)
   );

   pipe_gear_tx #(
      .SYM_W  (SYM_W),
      .N_SYMS (NARROW_SYMS),
      .STAGES (TX_STAGES)
   ) u_tx (
      .clk_fast  (clk_fast),
      .clk_half  (clk_half),
      .rst       (rst),
      .slot      (slot),
      .tx_data_w (tx_data_w),
      .tx_k_w    (tx_k_w),
      .tx_data_n (tx_data_n),
      .tx_k_n    (tx_k_n)
   );

   assert_reset_clears_R1: assert property (
      @(posedge clk_half) $past(rst) |-> (rx_data_w == '0 && rx_valid_w == 1'b0 &&
                                          phy_status_w == '0 && rx_status_w == '0)
   );

endmodule

// File: tb/pipe_gearbox_tb.sv
`timescale 1ns/1ps
module pipe_gearbox_tb;

   localparam int EXP_RX_LAT = 1;
   localparam int EXP_TX_LAT = 1;

   logic        clk_fast = 1'b0;
   logic        clk_half = 1'b0;
   logic        rst = 1'b1;
   logic        phase_sel = 1'b0;
   logic [15:0] rx_data_n = '0;
   logic [1:0]  rx_k_n = '0;
   logic        rx_valid_n = 1'b0;
   logic        phy_status_n = 1'b0;
   logic [2:0]  rx_status_n = '0;
   logic [31:0] rx_data_w;
   logic [3:0]  rx_k_w;
   logic        rx_valid_w;
   logic [1:0]  phy_status_w;
   logic [5:0]  rx_status_w;
   logic [31:0] tx_data_w = '0;
   logic [3:0]  tx_k_w = '0;
   logic [15:0] tx_data_n;
   logic [1:0]  tx_k_n;

   pipe_gearbox u_dut (
      .clk_fast(clk_fast), .clk_half(clk_half), .rst(rst), .phase_sel(phase_sel),
      .rx_data_n(rx_data_n), .rx_k_n(rx_k_n), .rx_valid_n(rx_valid_n),
      .phy_status_n(phy_status_n), .rx_status_n(rx_status_n),
      .rx_data_w(rx_data_w), .rx_k_w(rx_k_w), .rx_valid_w(rx_valid_w),
      .phy_status_w(phy_status_w), .rx_status_w(rx_status_w),
      .tx_data_w(tx_data_w), .tx_k_w(tx_k_w), .tx_data_n(tx_data_n), .tx_k_n(tx_k_n)
   );

   // 250 MHz full-rate clock; 125 MHz half-rate clock rising with it
   initial forever begin #2 clk_fast = 1'b1; #2 clk_fast = 1'b0; end
   initial begin #2; forever begin clk_half = 1'b1; #4; clk_half = 1'b0; #4; end end

   int wc = 0;
   always @(posedge clk_half) wc <= wc + 1;

   int n_cmp = 0;
   int n_bad = 0;
   string tag = "run1";

   typedef struct {
      int          due;
      logic [31:0] data;
      logic [3:0]  k;
      logic        valid;
      logic [1:0]  phy;
      logic [5:0]  stat;
   } rx_exp_t;

   typedef struct {
      int          due;
      logic [31:0] data;
      logic [3:0]  k;
   } tx_exp_t;

   rx_exp_t rx_q[$];
   tx_exp_t tx_q[$];
   rx_exp_t re;
   tx_exp_t te;
   bit      tx_pending = 1'b0;

   task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // ---------------- drivers
   task automatic rx_pair(input logic [15:0] d0, input logic [1:0] k0, input logic v0,
                          input logic p0, input logic [2:0] s0,
                          input logic [15:0] d1, input logic [1:0] k1, input logic v1,
                          input logic p1, input logic [2:0] s1);
      rx_exp_t e;
      do @(negedge clk_fast); while (clk_half !== 1'b0);
      e.due = wc + 1 + EXP_RX_LAT;
      e.data = {d1, d0}; e.k = {k1, k0}; e.valid = v0 & v1;
      e.phy = {p1, p0}; e.stat = {s1, s0};
      rx_q.push_back(e);
      rx_data_n = d0; rx_k_n = k0; rx_valid_n = v0; phy_status_n = p0; rx_status_n = s0;
      @(negedge clk_fast);
      rx_data_n = d1; rx_k_n = k1; rx_valid_n = v1; phy_status_n = p1; rx_status_n = s1;
   endtask

   task automatic tx_word(input logic [31:0] d, input logic [3:0] k);
      tx_exp_t e;
      do @(negedge clk_fast); while (clk_half !== 1'b0);
      e.due = wc + 1 + EXP_TX_LAT;
      e.data = d; e.k = k;
      tx_q.push_back(e);
      tx_data_w = d; tx_k_w = k;
   endtask

   // ---------------- monitors
   always @(negedge clk_fast) begin
      if (!rst && clk_half === 1'b1) begin
         if (rx_q.size() > 0 && rx_q[0].due <= wc) begin
            re = rx_q.pop_front();
            check("R6 rx arrival cycle", 64'(wc), 64'(re.due));
            check("R2 rx data order", 64'(rx_data_w), 64'(re.data));
            check("R2 rx K order", 64'(rx_k_w), 64'(re.k));
            check("R5 rx valid AND", 64'(rx_valid_w), 64'(re.valid));
            check("R3 phy status split", 64'(phy_status_w), 64'(re.phy));
            check("R4 rx status split", 64'(rx_status_w), 64'(re.stat));
         end
      end
   end

   always @(negedge clk_fast) begin
      if (!rst) begin
         if (clk_half === 1'b1) begin
            if (tx_q.size() > 0 && tx_q[0].due <= wc) begin
               te = tx_q.pop_front();
               check("R8 tx start cycle", 64'(wc), 64'(te.due));
               check("R7 tx low data first", 64'(tx_data_n), 64'(te.data[15:0]));
               check("R7 tx low K first", 64'(tx_k_n), 64'(te.k[1:0]));
               tx_pending = 1'b1;
            end
         end else if (tx_pending) begin
            check("R7 R8 tx high data next", 64'(tx_data_n), 64'(te.data[31:16]));
            check("R7 tx high K next", 64'(tx_k_n), 64'(te.k[3:2]));
            tx_pending = 1'b0;
         end
      end
   end

   task automatic check_reset_outputs();
      check("R1 rx data reset", 64'(rx_data_w), 64'h0);
      check("R1 rx K reset", 64'(rx_k_w), 64'h0);
      check("R1 rx valid reset", 64'(rx_valid_w), 64'h0);
      check("R1 phy status reset", 64'(phy_status_w), 64'h0);
      check("R1 rx status reset", 64'(rx_status_w), 64'h0);
      check("R1 tx data reset", 64'(tx_data_n), 64'h0);
      check("R1 tx K reset", 64'(tx_k_n), 64'h0);
   endtask

   task automatic rx_stream();
      rx_pair(16'h0201, 2'b00, 1, 0, 3'd0, 16'h0403, 2'b00, 1, 0, 3'd0);
      rx_pair(16'hBC1C, 2'b01, 1, 0, 3'd0, 16'h3CF7, 2'b10, 1, 0, 3'd0);
      rx_pair(16'h1111, 2'b11, 0, 0, 3'd0, 16'h2222, 2'b00, 1, 0, 3'd0);
      rx_pair(16'h3333, 2'b00, 1, 0, 3'd0, 16'h4444, 2'b01, 0, 0, 3'd0);
      rx_pair(16'h5555, 2'b10, 1, 1, 3'd0, 16'h6666, 2'b00, 1, 0, 3'd0);
      rx_pair(16'h7777, 2'b00, 1, 0, 3'd0, 16'h8888, 2'b11, 1, 1, 3'd0);
      rx_pair(16'h99AA, 2'b01, 1, 1, 3'b101, 16'hBBCC, 2'b10, 1, 0, 3'b010);
      for (int i = 0; i < 8; i++) begin
         rx_pair(16'(i * 16'h1357 + 16'h0F0F), 2'(i), 1'(i >> 1), 1'(i), 3'(i),
                 16'(i * 16'h2468 + 16'hA5A5), 2'(i + 1), 1'(i >> 2), 1'(i >> 1), 3'(7 - i));
      end
   endtask

   task automatic tx_stream();
      tx_word(32'h0403_0201, 4'b0000);
      tx_word(32'hA1B2_C3D4, 4'b0001);
      tx_word(32'hBC1C_3CF7, 4'b1010);
      tx_word(32'hFFFF_0000, 4'b1100);
      tx_word(32'h0000_FFFF, 4'b0011);
      for (int i = 0; i < 8; i++) begin
         tx_word(32'(i * 32'h1021_4081 + 32'h5A5A_0F0F), 4'(i * 3));
      end
   endtask

   // ---------------- watchdog
   initial begin
      #1600000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   // ---------------- main sequence
   initial begin
      repeat (4) @(posedge clk_half);
      @(negedge clk_fast);
      check_reset_outputs();
      // release so that the next full-rate edge coincides with a half-rate edge
      do @(negedge clk_fast); while (clk_half !== 1'b0);
      rst = 1'b0;
      fork
         rx_stream();
         tx_stream();
      join
      wait (rx_q.size() == 0 && tx_q.size() == 0 && !tx_pending);
      repeat (2) @(posedge clk_half);

      // second run: reset with busy inputs, then the opposite phase select
      @(negedge clk_fast);
      rst = 1'b1;
      phase_sel = 1'b1;
      rx_data_n = 16'hFFFF; rx_k_n = 2'b11; rx_valid_n = 1'b1;
      phy_status_n = 1'b1; rx_status_n = 3'b111;
      tx_data_w = 32'hFFFF_FFFF; tx_k_w = 4'hF;
      repeat (3) @(posedge clk_half);
      @(negedge clk_fast);
      check_reset_outputs();
      rx_data_n = '0; rx_k_n = '0; rx_valid_n = 1'b0; phy_status_n = 1'b0; rx_status_n = '0;
      tx_data_w = '0; tx_k_w = '0;
      tag = "R9 phase1";
      // release so that the next full-rate edge falls between half-rate edges
      do @(negedge clk_fast); while (clk_half !== 1'b1);
      rst = 1'b0;
      fork
         begin
            rx_pair(16'hCAFE, 2'b01, 1, 1, 3'b100, 16'hBEEF, 2'b10, 1, 0, 3'b011);
            rx_pair(16'h1234, 2'b00, 1, 0, 3'b001, 16'h5678, 2'b11, 0, 1, 3'b110);
            rx_pair(16'h0F1E, 2'b10, 1, 0, 3'b000, 16'h2D3C, 2'b01, 1, 0, 3'b000);
         end
         begin
            tx_word(32'hDEAD_BEEF, 4'b0110);
            tx_word(32'h0123_4567, 4'b1001);
            tx_word(32'h89AB_CDEF, 4'b0000);
         end
      join
      wait (rx_q.size() == 0 && tx_q.size() == 0 && !tx_pending);
      repeat (2) @(posedge clk_half);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule